// File: doc/BRIEF.md
# Daisy-Chain Converter Readout Controller

This block is the host end of a string of serial sample converters wired in cascade. All converters share one conversion-start line and one serial clock from this controller. The first converter's serial input is grounded, each converter's output feeds the next one's input, and the output of the final converter returns to the controller's serial data input.

A single-cycle sample request starts a frame. The controller holds the serial clock low and raises conversion-start. It waits a fixed number of system clock cycles for the conversion to finish. It then runs the serial clock for 16 bits per converter, taking in one bit before each falling edge. The bit stream carries the words in reverse chain order, so the controller tags each word with the position of the converter that produced it. Conversion-start stays high until the frame has been read out. A done pulse then marks the end of the frame.

Top module: `dchain_ctrl`

## Requirements
- R1: While reset is high and just after it is released, `conv_o`, `sclk_o`, `word_vld_o` and `done_o` are all low.
- R2: A `start_req` seen while idle raises `conv_o` one cycle later, and `sclk_o` is low in the cycle where `conv_o` rises. Each request starts exactly one frame.
- R3: The first rising edge of `sclk_o` comes `CONV_CYC + CLK_DIV/2` system cycles after `conv_o` rises.
- R4: During readout, each high phase of `sclk_o` lasts `CLK_DIV/2` cycles, and consecutive rising edges are `CLK_DIV` cycles apart.
- R5: Each frame has exactly `16*N_DEV` falling edges of `sclk_o`.
- R6: `sdi` is sampled in the last system cycle of each `sclk_o` high phase. The first sample is therefore the MSB that is present when the conversion ends, before any falling edge.
- R7: A frame produces `N_DEV` words. The index `word_idx_o` starts at `N_DEV` and counts down by one to 1. The word with index k holds the 16-bit result of the k-th converter from the grounded end, with the first bit received as its MSB.
- R8: `word_vld_o` is a one-cycle pulse. It comes in the cycle after the last bit of that word is sampled.
- R9: `sclk_o` is high only while `conv_o` is high. `conv_o` falls in the cycle after the final falling edge. `done_o` pulses once, in the cycle where `conv_o` falls, which is the cycle after the last `word_vld_o`.
- R10: `start_req` has no effect while a frame is in progress. It does not restart, stretch or repeat the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Request one sampling frame |
| sdi | input | 1 | Serial data from the last converter in the chain |
| conv_o | output | 1 | Shared conversion-start to all converters |
| sclk_o | output | 1 | Shared serial clock to all converters |
| word_o | output | 16 | Received converter result |
| word_idx_o | output | IDX_W | Chain position of `word_o` (1 is the grounded end) |
| word_vld_o | output | 1 | `word_o` and `word_idx_o` are valid this cycle |
| done_o | output | 1 | Frame finished |

## Verification
The bench models a three-converter cascade of shift registers and runs it through five frames of results.

- An all-zero frame and an all-one frame show whether a constant bit leaks in from the grounded input.
- Alternating patterns expose a one-bit slip between sampling and the falling edge.
- Distinct words per converter show whether the de-interleaving assigns the right index to each word.
- A frame of 0x8000, 0x0001 and 0x7FFE puts single set or clear bits at word boundaries, where an off-by-one in the bit or word counter would show.

A further frame receives repeated requests during readout, to confirm that the controller ignores them.

// File: rtl/dchain_pkg.sv
package dchain_pkg;

    // Width of each converter result in bits
    localparam int SAMPLE_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CONV  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_FIN   = 2'd3
    } dchain_state_e;

    // Bits needed to hold values 0..n
    function automatic int idx_width(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

    // Bits needed to count 0..n-1
    function automatic int cnt_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/dchain_sclk_gen.sv
module dchain_sclk_gen
    import dchain_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic sclk_o,
    output logic smp_o
);
    localparam int HALF = CLK_DIV / 2;
    localparam int PH_W = cnt_width(CLK_DIV);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLK_DIV - 1);
    localparam logic [PH_W-1:0] PH_HALF = PH_W'(HALF);

    logic [PH_W-1:0] ph_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            ph_q <= '0;
        end else if (ph_q == PH_LAST) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_q + PH_W'(1);
        end
    end

    // Low for the first half of each period, high for the second half
    assign sclk_o = run && (ph_q >= PH_HALF);
    // Take in data in the final cycle of the high phase
    assign smp_o  = run && (ph_q == PH_LAST);

    // Every falling edge has a sample in the cycle just before it
    assert_sample_before_fall_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk_o) |-> $past(smp_o));

endmodule

// File: rtl/dchain_deser.sv
module dchain_deser
    import dchain_pkg::*;
#(
    parameter int N_DEV = 3,
    parameter int IDX_W = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                smp,
    input  logic                sdi,
    output logic [SAMPLE_W-1:0] word_o,
    output logic [IDX_W-1:0]    idx_o,
    output logic                vld_o,
    output logic                last_o
);
    localparam int BIT_W = cnt_width(SAMPLE_W);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(SAMPLE_W - 1);
    localparam logic [IDX_W-1:0] W_LAST   = IDX_W'(N_DEV - 1);
    localparam logic [IDX_W-1:0] IDX_TOP  = IDX_W'(N_DEV);

    logic [BIT_W-1:0]    bit_q;
    logic [IDX_W-1:0]    wcnt_q;
    logic [SAMPLE_W-1:0] sr_q;
    logic [SAMPLE_W-1:0] sr_nxt;
    logic                end_word;

    assign sr_nxt   = {sr_q[SAMPLE_W-2:0], sdi};
    assign end_word = smp && (bit_q == BIT_LAST);
    assign last_o   = end_word && (wcnt_q == W_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q  <= '0;
            wcnt_q <= '0;
            sr_q   <= '0;
            word_o <= '0;
            idx_o  <= '0;
            vld_o  <= 1'b0;
        end else begin
            vld_o <= 1'b0;
            if (clr) begin
                bit_q  <= '0;
                wcnt_q <= '0;
            end else if (smp) begin
                sr_q  <= sr_nxt;
                bit_q <= end_word ? '0 : bit_q + BIT_W'(1);
                if (end_word) begin
                    word_o <= sr_nxt;
                    // The stream carries the far end of the chain first
                    idx_o  <= IDX_TOP - wcnt_q;
                    vld_o  <= 1'b1;
                    wcnt_q <= wcnt_q + IDX_W'(1);
                end
            end
        end
    end

    assert_vld_single_R8: assert property (@(posedge clk) disable iff (rst)
        vld_o |=> !vld_o);

    assert_idx_in_range_R7: assert property (@(posedge clk) disable iff (rst)
        vld_o |-> (idx_o >= IDX_W'(1) && idx_o <= IDX_TOP));

endmodule

// File: rtl/dchain_ctrl.sv
module dchain_ctrl
    import dchain_pkg::*;
#(
    parameter  int N_DEV    = 3,
    parameter  int CLK_DIV  = 4,
    parameter  int CONV_CYC = 20,
    localparam int IDX_W    = idx_width(N_DEV)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_req,
    input  logic                sdi,
    output logic                conv_o,
    output logic                sclk_o,
    output logic [SAMPLE_W-1:0] word_o,
    output logic [IDX_W-1:0]    word_idx_o,
    output logic                word_vld_o,
    output logic                done_o
);
    localparam int CONV_W = cnt_width(CONV_CYC);
    localparam logic [CONV_W-1:0] CONV_LAST = CONV_W'(CONV_CYC - 1);

    dchain_state_e     st_q;
    logic [CONV_W-1:0] tmr_q;
    logic              run;
    logic              smp;
    logic              last_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            tmr_q  <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    tmr_q <= '0;
                    if (start_req) st_q <= ST_CONV;
                end
                ST_CONV: begin
                    if (tmr_q == CONV_LAST) st_q <= ST_SHIFT;
                    else                    tmr_q <= tmr_q + CONV_W'(1);
                end
                ST_SHIFT: begin
                    if (last_bit) st_q <= ST_FIN;
                end
                default: begin
                    // Final falling edge happens here with conv still high
                    st_q   <= ST_IDLE;
                    done_o <= 1'b1;
                end
            endcase
        end
    end

    assign conv_o = (st_q != ST_IDLE);
    assign run    = (st_q == ST_SHIFT);

    dchain_sclk_gen #(
        .CLK_DIV (CLK_DIV)
    ) sclk_i (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .sclk_o (sclk_o),
        .smp_o  (smp)
    );

    dchain_deser #(
        .N_DEV (N_DEV),
        .IDX_W (IDX_W)
    ) deser_i (
        .clk    (clk),
        .rst    (rst),
        .clr    (!conv_o),
        .smp    (smp),
        .sdi    (sdi),
        .word_o (word_o),
        .idx_o  (word_idx_o),
        .vld_o  (word_vld_o),
        .last_o (last_bit)
    );

    assert_sclk_low_at_conv_rise_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(conv_o) |-> !sclk_o);

    assert_sclk_inside_frame_R9: assert property (@(posedge clk) disable iff (rst)
        sclk_o |-> conv_o);

    assert_done_after_last_word_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(word_vld_o) && !conv_o));

    assert_request_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SHIFT && start_req && !last_bit) |=> (st_q == ST_SHIFT));

endmodule

// File: tb/dchain_ctrl_tb_top.sv
module dchain_ctrl_tb_top;
    localparam int N        = 3;
    localparam int DIV      = 4;
    localparam int CONV     = 20;
    localparam int HALF     = DIV / 2;
    localparam int IW       = $clog2(N + 1);
    localparam int NV       = 5;
    localparam logic [15:0] VEC [0:NV*N-1] = '{
        16'h0000, 16'h0000, 16'h0000,
        16'hFFFF, 16'hFFFF, 16'hFFFF,
        16'hAAAA, 16'h5555, 16'hAAAA,
        16'h1234, 16'h5678, 16'h9ABC,
        16'h8000, 16'h0001, 16'h7FFE
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_req = 1'b0;
    logic          sdi;
    logic          conv_o, sclk_o, word_vld_o, done_o;
    logic [15:0]   word_o;
    logic [IW-1:0] word_idx_o;

    always #2 clk = ~clk;

    dchain_ctrl #(.N_DEV(N), .CLK_DIV(DIV), .CONV_CYC(CONV)) dut_i (
        .clk(clk), .rst(rst), .start_req(start_req), .sdi(sdi),
        .conv_o(conv_o), .sclk_o(sclk_o), .word_o(word_o),
        .word_idx_o(word_idx_o), .word_vld_o(word_vld_o), .done_o(done_o)
    );

    // Cascade of simple converter models; device g+1 is g positions from ground
    logic [15:0]  dev_val [N];
    logic [N-1:0] dout_w;
    assign sdi = dout_w[N-1];

    for (genvar g = 0; g < N; g++) begin : g_dev
        logic [15:0] sr = '0;
        logic conv_d = 1'b0, sclk_d = 1'b0;
        logic din;
        if (g == 0) begin : g_gnd
            assign din = 1'b0;
        end else begin : g_link
            assign din = dout_w[g-1];
        end
        assign dout_w[g] = sr[15];
        always @(posedge clk) begin
            conv_d <= conv_o;
            sclk_d <= sclk_o;
            if (conv_o && !conv_d)       sr <= dev_val[g];
            else if (!sclk_o && sclk_d)  sr <= {sr[14:0], din};
        end
    end

    int n_tests = 0, n_fail = 0;
    int conv_rises, lat, falls, hi_run, since_rise, nwords, done_cnt;
    bit sclk_rose_once, rise_gap_valid;
    bit bad_rise_sclk, bad_period, bad_sclk_out, bad_vld, bad_order, bad_done;
    bit conv_p = 0, sclk_p = 0, vld_p = 0;
    logic [15:0] got [N];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        conv_rises = 0; lat = 0; falls = 0; hi_run = 0; since_rise = 0;
        nwords = 0; done_cnt = 0; sclk_rose_once = 0; rise_gap_valid = 0;
        bad_rise_sclk = 0; bad_period = 0; bad_sclk_out = 0; bad_vld = 0;
        bad_order = 0; bad_done = 0;
        for (int k = 0; k < N; k++) got[k] = 16'hDEAD;
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (conv_o && !conv_p) begin
                conv_rises++;
                if (sclk_o) bad_rise_sclk = 1;
            end
            if (conv_o && !sclk_rose_once && !sclk_o) lat++;
            since_rise++;
            if (sclk_o && !sclk_p) begin
                sclk_rose_once = 1;
                if (rise_gap_valid && since_rise != DIV) bad_period = 1;
                since_rise = 0;
                rise_gap_valid = 1;
            end
            if (sclk_o) hi_run++;
            if (!sclk_o && sclk_p) begin
                falls++;
                if (hi_run != HALF) bad_period = 1;
                hi_run = 0;
            end
            if (sclk_o && !conv_o) bad_sclk_out = 1;
            if (word_vld_o) begin
                if (vld_p) bad_vld = 1;
                if (int'(word_idx_o) != N - nwords) bad_order = 1;
                if (word_idx_o >= 1 && int'(word_idx_o) <= N) got[word_idx_o-1] = word_o;
                nwords++;
            end
            if (done_o) begin
                done_cnt++;
                if (conv_o || !conv_p || !vld_p) bad_done = 1;
            end
        end
        conv_p = conv_o; sclk_p = sclk_o; vld_p = word_vld_o;
    end

    task automatic run_frame(input int v, input bit extra);
        bit timed_out;
        @(posedge clk);
        clear_mon();
        for (int k = 0; k < N; k++) dev_val[k] = VEC[v*N + k];
        @(negedge clk); start_req = 1'b1;
        @(negedge clk); start_req = 1'b0;
        timed_out = 1;
        for (int c = 0; c < 2000; c++) begin
            @(negedge clk);
            if (extra) start_req = (c == 30 || c == 120 || c == 200);
            if (done_cnt != 0) begin timed_out = 0; break; end
        end
        start_req = 1'b0;
        check(!timed_out, "R9", "frame finished (watchdog)", done_cnt, 1);
        check(!bad_rise_sclk && conv_rises == 1, "R2", "one conv rise with sclk low",
              conv_rises, 1);
        check(lat == CONV + HALF, "R3", "conv rise to first sclk rise", lat, CONV + HALF);
        check(!bad_period, "R4", "sclk high phase and period", int'(bad_period), 0);
        check(falls == 16 * N, "R5", "falling edges per frame", falls, 16 * N);
        for (int k = 0; k < N; k++)
            check(got[k] == dev_val[k], "R6 R7", $sformatf("word of device %0d", k + 1),
                  int'(got[k]), int'(dev_val[k]));
        check(!bad_order && nwords == N, "R7", "word count and descending index", nwords, N);
        check(!bad_vld, "R8", "valid is a single-cycle pulse", int'(bad_vld), 0);
        check(!bad_done && done_cnt == 1 && !bad_sclk_out, "R9", "conv fall and done timing",
              done_cnt, 1);
        if (extra) begin
            @(posedge clk);
            clear_mon();
            repeat (300) @(negedge clk);
            check(conv_rises == 0 && nwords == 0 && done_cnt == 0, "R10",
                  "no frame from requests made while busy", conv_rises, 0);
        end
    endtask

    initial begin
        clear_mon();
        for (int k = 0; k < N; k++) dev_val[k] = '0;
        repeat (4) @(negedge clk);
        check(!conv_o && !sclk_o && !word_vld_o && !done_o, "R1", "outputs in reset",
              {conv_o, sclk_o, word_vld_o, done_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!conv_o && !sclk_o && !word_vld_o && !done_o, "R1", "outputs after reset",
              {conv_o, sclk_o, word_vld_o, done_o}, 0);
        for (int v = 0; v < NV; v++) run_frame(v, 1'b0);
        run_frame(3, 1'b1);
        run_frame(4, 1'b0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule